// File: doc/BRIEF.md
# LCD controller register and interrupt unit

This block is the software-visible register file of a framebuffer LCD controller. It decodes a 256-byte window on a simple 32-bit read/write bus and stores a control word, three timing words and a sub-panel word. It also keeps three sticky status flags (frame finished, palette loaded, sync lost) that the frame-fetch engine raises through dedicated set inputs.

The flags and the two interrupt-enable bits of the control word are combined into one level interrupt. Writing the enable bit of the control word starts and stops the fetch engine. A 0-to-1 change produces a one-cycle start pulse and a 1-to-0 change produces a one-cycle stop pulse. Stopping the controller reports a finished frame by itself, unless the palette-only load mode is selected.

Readback is not a plain echo. Some words come back with constant ones forced into fixed bit positions. The width and height fields hold the programmed count minus one. The status word is read-only.

Top module: `lcdc_regs`

## Requirements
- R1: Word 0x00 (control) keeps enable in bit 0, mono in bit 1, the interrupt-enable pair in bits 4:3, the panel-type bit in bit 7 and the load mode in bits 21:20. All other written bits are kept under mask 0x01CFF300. A read returns these fields in place, returns the panel-type bit again at bit 23, and ORs in 0xFE000C34.
- R2: Word 0x04 stores the full write and reads it back with bits 3:0 forced to one. Word 0x08 stores the full write and reads it back unchanged. Word 0x0C stores the full write and reads it back ORed with 0xFC000000. In 0x04 and 0x08, bits 9:0 hold width-1 and height-1.
- R3: Word 0x10 (status) reads palette-loaded at bit 6, sync-lost at bit 2 and frame-finished at bit 0, with all other bits zero. Writes to it change nothing.
- R4: Word 0x14 keeps only the written bits under mask 0xA1FFFFFF.
- R5: `irq` is high exactly when frame-finished is set with interrupt-enable bit 3 set, or palette-loaded is set with bit 4 set, or sync-lost is set. It follows the flags and the mask from the same clock edge.
- R6: A control write that changes enable from 1 to 0 clears sync-lost. It also sets frame-finished unless the new load mode is 1.
- R7: A control write that changes enable from 0 to 1 clears frame-finished and palette-loaded and pulses `en_rise` for one cycle. A change from 1 to 0 pulses `en_fall` for one cycle. A control write that leaves enable unchanged pulses neither.
- R8: A high set input makes its flag 1 on the next edge, and the flag stays 1 until R6 or R7 clears it. In the same cycle, the clear of R6/R7 wins over a set input.
- R9: An access whose byte address is not 0x00, 0x04, 0x08, 0x0C, 0x10 or 0x14 (including misaligned ones) writes nothing, reads as zero and pulses `bad_addr` for one cycle.
- R10: Reset clears every stored field and flag. `irq`, `en_rise`, `en_fall`, `bad_addr` and `bus_rdata` are then zero.
- R11: `bus_rdata` is updated on the edge that samples `bus_rd` and holds between reads. A read in the same cycle as a write to the same word returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address within the window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bad_addr | output | 1 | One-cycle pulse on an access to an undefined address |
| frame_done_set | input | 1 | Fetch engine: frame finished |
| palette_done_set | input | 1 | Fetch engine: palette loaded |
| sync_error_set | input | 1 | Fetch engine: sync lost |
| irq | output | 1 | Level interrupt |
| en_rise | output | 1 | One-cycle start pulse to the fetch engine |
| en_fall | output | 1 | One-cycle stop pulse to the fetch engine |

## Verification
The assertions assume that the bus strobes and the set inputs are known (0 or 1) whenever reset is low. They also assume that read data is only consumed on the cycle after a read strobe. The stimulus drives every input to a defined level in every cycle and changes inputs only on the falling clock edge. Random traffic mixes reads, writes, same-cycle read-and-write, misaligned and out-of-range addresses, and set pulses. Directed sequences cover the disable cases with load mode 1 and with another mode, and a set input that arrives together with an enable edge.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;
  localparam int DATA_W   = 32;
  localparam int NUM_REGS = 6;

  localparam int IDX_CTRL = 0;
  localparam int IDX_TIM0 = 1;
  localparam int IDX_TIM1 = 2;
  localparam int IDX_TIM2 = 3;
  localparam int IDX_STAT = 4;
  localparam int IDX_SUB  = 5;

  localparam logic [DATA_W-1:0] CTRL_FORCE = 32'hFE00_0C34;
  localparam logic [DATA_W-1:0] CTRL_KEEP  = 32'h01CF_F300;
  localparam logic [DATA_W-1:0] TIM0_FORCE = 32'h0000_000F;
  localparam logic [DATA_W-1:0] TIM2_FORCE = 32'hFC00_0000;
  localparam logic [DATA_W-1:0] SUB_KEEP   = 32'hA1FF_FFFF;

  localparam int EN_BIT   = 0;
  localparam int MONO_BIT = 1;
  localparam int MASK_LO  = 3;
  localparam int TFT_BIT  = 7;
  localparam int MODE_LO  = 20;
  localparam int TFT_ECHO = 23;

  localparam int STAT_FRAME = 0;
  localparam int STAT_SYNC  = 2;
  localparam int STAT_PAL   = 6;

  localparam logic [1:0] MODE_PAL_ONLY = 2'd1;

  typedef struct packed {
    logic [1:0]        mode;
    logic              tft;
    logic [1:0]        irq_mask;
    logic              mono;
    logic              en;
    logic [DATA_W-1:0] other;
  } ctrl_t;
endpackage

// File: rtl/lcdc_addr_dec.sv
module lcdc_addr_dec #(
  parameter int ADDR_W = 8,
  parameter int NREG   = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NREG-1:0]   sel,
  output logic              undef
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] word_idx;
  logic             aligned;

  assign word_idx = addr[ADDR_W-1:2];
  assign aligned  = (addr[1:0] == 2'b00);

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_sel
      assign sel[g] = aligned && (word_idx == IDX_W'(g));
    end
  endgenerate

  assign undef = ~|sel;
endmodule

// File: rtl/lcdc_cfg_regs.sv
module lcdc_cfg_regs
  import lcdc_pkg::*;
#(
  parameter int DIM_W = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [NUM_REGS-1:0]   sel,
  input  logic [DATA_W-1:0]     wdata,
  output ctrl_t                 ctrl_q,
  output ctrl_t                 ctrl_d,
  output logic [DATA_W-1:0]     tim0_q,
  output logic [DATA_W-1:0]     tim1_q,
  output logic [DATA_W-1:0]     tim2_q,
  output logic [DATA_W-1:0]     sub_q,
  output logic                  rise_evt,
  output logic                  fall_evt,
  output logic                  en_rise,
  output logic                  en_fall
);
  localparam int HI_W = DATA_W - DIM_W;

  logic [DIM_W-1:0] t0_dim, t1_dim;
  logic [HI_W-1:0]  t0_hi, t1_hi;
  logic             wr_ctrl;

  assign wr_ctrl = wr_en && sel[IDX_CTRL];

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d.mode     = wdata[MODE_LO +: 2];
      ctrl_d.tft      = wdata[TFT_BIT];
      ctrl_d.irq_mask = wdata[MASK_LO +: 2];
      ctrl_d.mono     = wdata[MONO_BIT];
      ctrl_d.en       = wdata[EN_BIT];
      ctrl_d.other    = wdata & CTRL_KEEP;
    end
  end

  assign rise_evt = !rst && wr_ctrl &&  wdata[EN_BIT] && !ctrl_q.en;
  assign fall_evt = !rst && wr_ctrl && !wdata[EN_BIT] &&  ctrl_q.en;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      t0_dim  <= '0;
      t0_hi   <= '0;
      t1_dim  <= '0;
      t1_hi   <= '0;
      tim2_q  <= '0;
      sub_q   <= '0;
      en_rise <= 1'b0;
      en_fall <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      en_rise <= rise_evt;
      en_fall <= fall_evt;
      if (wr_en && sel[IDX_TIM0]) begin
        t0_dim <= wdata[DIM_W-1:0];
        t0_hi  <= wdata[DATA_W-1:DIM_W];
      end
      if (wr_en && sel[IDX_TIM1]) begin
        t1_dim <= wdata[DIM_W-1:0];
        t1_hi  <= wdata[DATA_W-1:DIM_W];
      end
      if (wr_en && sel[IDX_TIM2]) tim2_q <= wdata;
      if (wr_en && sel[IDX_SUB])  sub_q  <= wdata & SUB_KEEP;
    end
  end

  assign tim0_q = {t0_hi, t0_dim};
  assign tim1_q = {t1_hi, t1_dim};

  // R7
  en_pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(en_rise && en_fall));
  // R7
  en_rise_state_chk: assert property (@(posedge clk) disable iff (rst)
    en_rise |-> ctrl_q.en);
  // R7
  en_fall_state_chk: assert property (@(posedge clk) disable iff (rst)
    en_fall |-> !ctrl_q.en);
endmodule

// File: rtl/lcdc_status.sv
module lcdc_status
  import lcdc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rise_evt,
  input  logic       fall_evt,
  input  logic [1:0] mode_d,
  input  logic [1:0] mask_d,
  input  logic       frame_set,
  input  logic       pal_set,
  input  logic       sync_set,
  output logic       frame_q,
  output logic       pal_q,
  output logic       sync_q,
  output logic       irq
);
  logic frame_n, pal_n, sync_n;

  always_comb begin
    frame_n = frame_q | frame_set;
    pal_n   = pal_q   | pal_set;
    sync_n  = sync_q  | sync_set;
    if (fall_evt) begin
      sync_n = 1'b0;
      if (mode_d != MODE_PAL_ONLY) frame_n = 1'b1;
    end
    if (rise_evt) begin
      frame_n = 1'b0;
      pal_n   = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= 1'b0;
      pal_q   <= 1'b0;
      sync_q  <= 1'b0;
      irq     <= 1'b0;
    end else begin
      frame_q <= frame_n;
      pal_q   <= pal_n;
      sync_q  <= sync_n;
      irq     <= (frame_n & mask_d[0]) | (pal_n & mask_d[1]) | sync_n;
    end
  end

  // R6
  fall_sync_clr_chk: assert property (@(posedge clk) disable iff (rst)
    $past(fall_evt) |-> !sync_q);
  // R6
  fall_frame_set_chk: assert property (@(posedge clk) disable iff (rst)
    $past(fall_evt && mode_d != MODE_PAL_ONLY) |-> frame_q);
  // R7
  rise_flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rise_evt) |-> (!frame_q && !pal_q));
  // R5
  sync_irq_chk: assert property (@(posedge clk) disable iff (rst)
    sync_q |-> irq);
  // R8
  sticky_sync_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(sync_q) && !$past(fall_evt)) |-> sync_q);
endmodule

// File: rtl/lcdc_regs.sv
module lcdc_regs
  import lcdc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DIM_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bad_addr,
  input  logic              frame_done_set,
  input  logic              palette_done_set,
  input  logic              sync_error_set,
  output logic              irq,
  output logic              en_rise,
  output logic              en_fall
);
  logic [NUM_REGS-1:0] sel;
  logic                undef;
  ctrl_t               ctrl_q, ctrl_d;
  logic [DATA_W-1:0]   tim0_q, tim1_q, tim2_q, sub_q;
  logic                rise_evt, fall_evt;
  logic                frame_q, pal_q, sync_q;
  logic [DATA_W-1:0]   words [NUM_REGS];
  logic [DATA_W-1:0]   rd_word;

  lcdc_addr_dec #(.ADDR_W(ADDR_W), .NREG(NUM_REGS)) u_dec (
    .addr  (bus_addr),
    .sel   (sel),
    .undef (undef)
  );

  lcdc_cfg_regs #(.DIM_W(DIM_W)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (bus_wr),
    .sel      (sel),
    .wdata    (bus_wdata),
    .ctrl_q   (ctrl_q),
    .ctrl_d   (ctrl_d),
    .tim0_q   (tim0_q),
    .tim1_q   (tim1_q),
    .tim2_q   (tim2_q),
    .sub_q    (sub_q),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt),
    .en_rise  (en_rise),
    .en_fall  (en_fall)
  );

  lcdc_status u_stat (
    .clk       (clk),
    .rst       (rst),
    .rise_evt  (rise_evt),
    .fall_evt  (fall_evt),
    .mode_d    (ctrl_d.mode),
    .mask_d    (ctrl_d.irq_mask),
    .frame_set (frame_done_set),
    .pal_set   (palette_done_set),
    .sync_set  (sync_error_set),
    .frame_q   (frame_q),
    .pal_q     (pal_q),
    .sync_q    (sync_q),
    .irq       (irq)
  );

  assign words[IDX_CTRL] = CTRL_FORCE | ctrl_q.other
                         | (DATA_W'(ctrl_q.tft)      << TFT_ECHO)
                         | (DATA_W'(ctrl_q.mode)     << MODE_LO)
                         | (DATA_W'(ctrl_q.tft)      << TFT_BIT)
                         | (DATA_W'(ctrl_q.irq_mask) << MASK_LO)
                         | (DATA_W'(ctrl_q.mono)     << MONO_BIT)
                         | (DATA_W'(ctrl_q.en)       << EN_BIT);
  assign words[IDX_TIM0] = tim0_q | TIM0_FORCE;
  assign words[IDX_TIM1] = tim1_q;
  assign words[IDX_TIM2] = tim2_q | TIM2_FORCE;
  assign words[IDX_STAT] = (DATA_W'(pal_q)   << STAT_PAL)
                         | (DATA_W'(sync_q)  << STAT_SYNC)
                         | (DATA_W'(frame_q) << STAT_FRAME);
  assign words[IDX_SUB]  = sub_q;

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (sel[i]) rd_word = rd_word | words[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      bad_addr  <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_word;
      bad_addr <= (bus_rd || bus_wr) && undef;
    end
  end

  // R9
  bad_addr_cause_chk: assert property (@(posedge clk) disable iff (rst)
    bad_addr |-> $past(bus_rd || bus_wr));
  // R9
  undef_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd && undef) |-> (bus_rdata == '0));
  // R1
  ctrl_force_chk: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd && sel[IDX_CTRL]) |-> ((bus_rdata & CTRL_FORCE) == CTRL_FORCE));
  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(bus_rd) && !$past(rst)) |-> $stable(bus_rdata));
endmodule

// File: tb/sim_lcdc_regs.sv
`timescale 1ns/1ps
module sim_lcdc_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bad_addr, irq, en_rise, en_fall;
  logic        fs = 1'b0, ps = 1'b0, ss = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lcdc_regs u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bad_addr(bad_addr),
    .frame_done_set(fs), .palette_done_set(ps), .sync_error_set(ss),
    .irq(irq), .en_rise(en_rise), .en_fall(en_fall)
  );

  // model state
  logic [1:0]  m_mode, m_mask;
  logic        m_tft, m_mono, m_en, m_fr, m_pal, m_sync;
  logic [31:0] m_other, m_t0, m_t1, m_t2, m_sub, m_rdata;

  task automatic model_reset();
    m_mode = 0; m_mask = 0; m_tft = 0; m_mono = 0; m_en = 0;
    m_fr = 0; m_pal = 0; m_sync = 0; m_other = 0;
    m_t0 = 0; m_t1 = 0; m_t2 = 0; m_sub = 0; m_rdata = 0;
  endtask

  function automatic int widx(input logic [7:0] a);
    if (a[1:0] != 2'b00 || a[7:2] > 6'd5) return -1;
    return int'(a[7:2]);
  endfunction

  function automatic logic [31:0] mread(input int idx);
    case (idx)
      0: return 32'hFE000C34 | m_other | ({31'd0, m_tft} << 23) | ({30'd0, m_mode} << 20)
              | ({31'd0, m_tft} << 7) | ({30'd0, m_mask} << 3) | ({31'd0, m_mono} << 1)
              | {31'd0, m_en};
      1: return m_t0 | 32'h0000000F;
      2: return m_t1;
      3: return m_t2 | 32'hFC000000;
      4: return {25'd0, m_pal, 3'd0, m_sync, 1'b0, m_fr};
      5: return m_sub;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string rtag_of(input int idx);
    case (idx)
      0: return "R1 control";
      1, 2, 3: return "R2 timing";
      4: return "R3 status";
      5: return "R4 subpanel";
      default: return "R9 undefined";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic rd, input logic [7:0] addr,
                      input logic [31:0] wd, input logic f_s, input logic p_s,
                      input logic s_s, input string rtag);
    int idx;
    logic rise, fall, nf, np, ns, exp_bad, exp_irq;
    logic [1:0] nmode, nmask;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = addr; bus_wdata = wd;
    fs = f_s; ps = p_s; ss = s_s;
    idx = widx(addr);
    if (rd) m_rdata = mread(idx);
    exp_bad = (wr || rd) && (idx < 0);
    rise = wr && idx == 0 && wd[0] && !m_en;
    fall = wr && idx == 0 && !wd[0] && m_en;
    nmode = (wr && idx == 0) ? wd[21:20] : m_mode;
    nmask = (wr && idx == 0) ? wd[4:3] : m_mask;
    nf = m_fr | f_s; np = m_pal | p_s; ns = m_sync | s_s;
    if (fall) begin ns = 0; if (nmode != 2'd1) nf = 1; end
    if (rise) begin nf = 0; np = 0; end
    m_fr = nf; m_pal = np; m_sync = ns;
    if (wr) begin
      case (idx)
        0: begin
          m_mode = wd[21:20]; m_tft = wd[7]; m_mask = wd[4:3];
          m_mono = wd[1]; m_en = wd[0]; m_other = wd & 32'h01CFF300;
        end
        1: m_t0 = wd;
        2: m_t1 = wd;
        3: m_t2 = wd;
        5: m_sub = wd & 32'hA1FFFFFF;
        default: ;
      endcase
    end
    exp_irq = (m_fr & m_mask[0]) | (m_pal & m_mask[1]) | m_sync;
    @(posedge clk);
    #1;
    chk("R5 irq", {31'd0, irq}, {31'd0, exp_irq});
    chk("R7 en_rise", {31'd0, en_rise}, {31'd0, rise});
    chk("R7 en_fall", {31'd0, en_fall}, {31'd0, fall});
    chk("R9 bad_addr", {31'd0, bad_addr}, {31'd0, exp_bad});
    if (rd) chk((rtag != "") ? rtag : rtag_of(idx), bus_rdata, m_rdata);
    else    chk("R11 rdata hold", bus_rdata, m_rdata);
  endtask

  task automatic rd_reg(input logic [7:0] a, input string tag);
    step(1'b0, 1'b1, a, 32'd0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    step(1'b1, 1'b0, a, d, 1'b0, 1'b0, 1'b0, "");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    // R10 outputs after reset
    chk("R10 irq", {31'd0, irq}, 32'd0);
    chk("R10 rdata", bus_rdata, 32'd0);
    chk("R10 pulses", {30'd0, en_rise, en_fall}, 32'd0);
    chk("R10 bad_addr", {31'd0, bad_addr}, 32'd0);
    for (int i = 0; i < 6; i++) rd_reg(8'(i * 4), "R10 reset readback");

    // R2 / R4 directed
    wr_reg(8'h04, 32'hFFFF_FC10);
    rd_reg(8'h04, "R2 timing0 forced low bits");
    wr_reg(8'h08, 32'h0012_34F0);
    rd_reg(8'h08, "R2 timing1 plain");
    wr_reg(8'h0C, 32'h0000_1234);
    rd_reg(8'h0C, "R2 timing2 forced high bits");
    wr_reg(8'h14, 32'hFFFF_FFFF);
    rd_reg(8'h14, "R4 subpanel mask");

    // R6 / R7: enable with both masks, then disable in mode 1 (frame stays 0)
    wr_reg(8'h00, 32'h0000_0019);
    wr_reg(8'h00, 32'h0010_0018);
    rd_reg(8'h10, "R6 mode1 disable keeps frame clear");
    // enable, disable in mode 0 -> frame set, irq
    wr_reg(8'h00, 32'h0000_0019);
    wr_reg(8'h00, 32'h0000_0018);
    rd_reg(8'h10, "R6 disable sets frame");
    // R8: enable together with a frame set -> clear wins
    step(1'b1, 1'b0, 8'h00, 32'h0000_0019, 1'b1, 1'b1, 1'b0, "");
    rd_reg(8'h10, "R8 enable clear beats set");
    // sync set with mask 0
    wr_reg(8'h00, 32'h0000_0001);
    step(1'b0, 1'b0, 8'h00, 32'd0, 1'b0, 1'b0, 1'b1, "");
    rd_reg(8'h10, "R8 sync sticky");
    // R3: status write ignored
    wr_reg(8'h10, 32'hFFFF_FFFF);
    rd_reg(8'h10, "R3 status write ignored");
    // R6: disable with sync set in same cycle -> clear wins
    step(1'b1, 1'b0, 8'h00, 32'h0010_0000, 1'b0, 1'b0, 1'b1, "");
    rd_reg(8'h10, "R6 disable clears sync");
    // R11: read and write same word same cycle
    step(1'b1, 1'b1, 8'h14, 32'h1234_5678, 1'b0, 1'b0, 1'b0, "R11 read old value");
    rd_reg(8'h14, "R4 subpanel after write");
    // R9 undefined and misaligned
    rd_reg(8'h18, "R9 undefined read");
    rd_reg(8'h02, "R9 misaligned read");
    wr_reg(8'hFC, 32'hDEAD_BEEF);
    // R7: rewrite same enable -> no pulse
    wr_reg(8'h00, 32'h0000_0000);
    rd_reg(8'h00, "R1 control readback");

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [7:0]  a;
      logic [31:0] d;
      logic        w, r;
      a = {3'd0, 3'($urandom % 8), 2'b00};
      if ($urandom % 16 == 0) a[1:0] = 2'($urandom % 4);
      if ($urandom % 32 == 0) a = 8'($urandom);
      d = $urandom;
      if (a == 8'h00 && ($urandom % 2 == 0)) d[0] = ~m_en;
      w = ($urandom % 3 == 0);
      r = ($urandom % 2 == 0);
      step(w, r, a, d, ($urandom % 8 == 0), ($urandom % 8 == 0),
           ($urandom % 24 == 0), "");
    end

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule